// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block runs the bus side of an instruction fetch for an 8-bit processor with a 16-bit address bus. A fetch takes four clock states, T1 to T4. On the rising edge that starts T1, the program counter goes onto the address bus. Half a clock later the active-low memory request and read strobes drop, so the address has half a cycle to settle. On the rising edge that starts T3, the block captures the opcode from the data bus. That same edge releases both strobes, so the data is latched before read goes inactive.

States T3 and T4 are reused as a dynamic-memory refresh slot. The refresh address is driven on the low address bits, the refresh strobe is held low, and a second memory-request pulse runs for one clock from the T3 falling edge. While this happens, the core is free to decode and execute the captured opcode. The opcode-valid flag is high for the one cycle that follows the capture.

The first-cycle strobe marks T1 and T2. A request present at the end of T4 starts the next fetch with no idle cycle in between. The block uses both clock edges: the state advances on rising edges, and a copy of the state taken on falling edges places the half-cycle strobe transitions.

Top module: `opfetch_seq`

## Requirements
- R1: On the rising edge that begins T1, the block latches `pc` and drives it on `addr` through T1 and T2. While idle, `addr` holds the last latched value.
- R2: `mreq_n` and `rd_n` are both low from the falling edge inside T1 until the rising edge that begins T3, and high at the start of T1.
- R3: `m1_n` is low from the rising edge that begins T1 until the rising edge that begins T3, and high otherwise.
- R4: On the rising edge that begins T3, `opcode` takes the value of `din`. It holds that value until the next capture.
- R5: `opcode_vld` is high for exactly the one clock cycle of T3 and low at all other times.
- R6: `rfsh_n` is low for all of T3 and T4. During those states `addr` carries `rfsh_addr` in its low RFSH_W bits and zeros in its upper bits.
- R7: During refresh, `mreq_n` is low from the falling edge in T3 to the falling edge in T4, while `rd_n` stays high.
- R8: `fetch_req` is sampled on a rising edge while idle or in T4. If it is high, the next state is T1, so fetches run back to back. If it is low, the block idles with all strobes high.
- R9: An asynchronous low `rst_n` forces all strobes high, `opcode_vld` low, `opcode` to 0 and `addr` to 0 immediately, even in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Request to run an opcode fetch |
| pc | input | ADDR_W | Program counter to fetch from |
| din | input | DATA_W | Data bus from memory |
| rfsh_addr | input | RFSH_W | Refresh row address |
| addr | output | ADDR_W | Address bus |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| m1_n | output | 1 | First-cycle marker, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| opcode | output | DATA_W | Captured opcode |
| opcode_vld | output | 1 | One-cycle pulse after capture |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data bus and an 8-bit refresh address. With these values, the zeroed upper address byte during refresh is visible next to a fully driven program counter. Every half clock is compared against an eight-entry strobe pattern, which covers both the falling-edge strobe transitions and the rising-edge ones. The sequences checked are isolated fetches, a chain of back-to-back fetches where T4 leads straight into T1, idle periods with no request, and a reset in the middle of T2.

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RFSH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] din,
  input  logic [RFSH_W-1:0] rfsh_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              m1_n,
  output logic              rfsh_n,
  output logic [DATA_W-1:0] opcode,
  output logic              opcode_vld
);

  localparam int HI_W = ADDR_W - RFSH_W;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_T4} st_t;

  st_t st, st_neg;
  logic [ADDR_W-1:0] pc_q;

  wire start = fetch_req && (st == S_IDLE || st == S_T4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      pc_q       <= '0;
      opcode     <= '0;
      opcode_vld <= 1'b0;
    end else begin
      opcode_vld <= 1'b0;
      case (st)
        S_T1:    st <= S_T2;
        S_T2: begin
          st         <= S_T3;
          opcode     <= din;
          opcode_vld <= 1'b1;
        end
        S_T3:    st <= S_T4;
        default: st <= start ? S_T1 : S_IDLE;
      endcase
      if (start) pc_q <= pc;
    end

  // falling-edge copy places the half-cycle strobe edges
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) st_neg <= S_IDLE;
    else        st_neg <= st;

  wire in_fetch = (st == S_T1 || st == S_T2);
  wire in_rfsh  = (st == S_T3 || st == S_T4);
  wire rd_phase = in_fetch && (st_neg == S_T1 || st_neg == S_T2);
  wire rf_pulse = (st_neg == S_T3);

  assign m1_n   = !in_fetch;
  assign rd_n   = !rd_phase;
  assign mreq_n = !(rd_phase || rf_pulse);
  assign rfsh_n = !in_rfsh;
  assign addr   = in_rfsh ? {{HI_W{1'b0}}, rfsh_addr} : pc_q;

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RFSH_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] din,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              m1_n,
  input logic              rfsh_n,
  input logic [DATA_W-1:0] opcode,
  input logic              opcode_vld
);

  a_r2_rd_inside_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mreq_n);

  a_r7_no_read_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> rd_n);

  a_r3_m1_not_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |-> rfsh_n);

  a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_vld |=> !opcode_vld);

  a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_vld |-> opcode == $past(din));

  a_r6_refresh_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n) |=> !rfsh_n);

endmodule

bind opfetch_seq opfetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .mreq_n(mreq_n), .rd_n(rd_n),
  .m1_n(m1_n), .rfsh_n(rfsh_n), .opcode(opcode), .opcode_vld(opcode_vld)
);

// File: tb/opfetch_seq_tb.sv
`timescale 1ns/1ps
module opfetch_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0, fetch_req = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  din = '0, rfsh_addr = '0;
  logic [15:0] addr;
  logic        mreq_n, rd_n, m1_n, rfsh_n, opcode_vld;
  logic [7:0]  opcode;
  int n_chk = 0, n_bad = 0;
  logic [7:0] prev_op = '0;

  always #2 clk = ~clk;

  opfetch_seq u_dut (.*);

  // per half clock: {m1_n, mreq_n, rd_n, rfsh_n, opcode_vld, refresh-addr select}
  localparam logic [5:0] PAT [8] = '{
    6'b011100, 6'b000100, 6'b000100, 6'b000100,
    6'b111011, 6'b101011, 6'b101001, 6'b111001};

  // fetch vectors: {pc, din, rfsh_addr, keep request into next fetch}
  localparam logic [32:0] VEC [6] = '{
    {16'h1234, 8'hA5, 8'h3C, 1'b0},
    {16'hFFFF, 8'h00, 8'h7F, 1'b0},
    {16'h0000, 8'hFF, 8'h00, 1'b1},
    {16'h8001, 8'h5A, 8'h01, 1'b1},
    {16'h4C3B, 8'h96, 8'h80, 1'b0},
    {16'hBEEF, 8'h0F, 8'hFE, 1'b0}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk(logic [15:0] exp_addr);
    chk("R8 m1_n idle", m1_n, 1); chk("R8 mreq_n idle", mreq_n, 1);
    chk("R8 rd_n idle", rd_n, 1); chk("R8 rfsh_n idle", rfsh_n, 1);
    chk("R5 vld idle", opcode_vld, 0); chk("R1 addr held", addr, exp_addr);
    chk("R4 opcode held", opcode, prev_op);
  endtask

  initial begin
    #5000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk("R9 reset m1_n", m1_n, 1); chk("R9 reset mreq_n", mreq_n, 1);
    chk("R9 reset rd_n", rd_n, 1); chk("R9 reset rfsh_n", rfsh_n, 1);
    chk("R9 reset vld", opcode_vld, 0); chk("R9 reset opcode", opcode, 0);
    chk("R9 reset addr", addr, 0);
    #8 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 idle_chk(16'h0000);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] vpc; logic [7:0] vd, vr; logic keep;
      {vpc, vd, vr, keep} = VEC[v];
      if (v == 0 || !VEC[v-1][0]) begin
        @(posedge clk); #1;
      end
      pc = vpc; din = vd; rfsh_addr = vr; fetch_req = 1'b1;
      for (int h = 0; h < 8; h++) begin
        logic [5:0] e;
        if (h % 2) @(negedge clk); else @(posedge clk);
        #1;
        if (h == 0) fetch_req = 1'b0;
        e = PAT[h];
        chk("R3 m1_n", m1_n, e[5]);
        chk(h < 4 ? "R2 mreq_n" : "R7 mreq_n", mreq_n, e[4]);
        chk(h < 4 ? "R2 rd_n" : "R7 rd_n", rd_n, e[3]);
        chk("R6 rfsh_n", rfsh_n, e[2]);
        chk("R5 opcode_vld", opcode_vld, e[1]);
        chk(e[0] ? "R6 refresh addr" : "R1 pc addr", addr, e[0] ? {8'h00, vr} : vpc);
        chk("R4 opcode", opcode, h < 4 ? prev_op : vd);
        if (h == 6 && keep) fetch_req = 1'b1;
      end
      prev_op = vd;
      if (!keep) begin
        @(posedge clk); #1 idle_chk(vpc);
        @(posedge clk); #1 idle_chk(vpc);
      end
    end

    // asynchronous reset inside T2
    @(posedge clk); #1 pc = 16'h2222; fetch_req = 1'b1;
    @(posedge clk); #1 fetch_req = 1'b0;
    @(posedge clk); #1;
    chk("R2 mreq_n in T2", mreq_n, 0);
    rst_n = 1'b0; #0.5;
    chk("R9 mid-fetch mreq_n", mreq_n, 1); chk("R9 mid-fetch rd_n", rd_n, 1);
    chk("R9 mid-fetch m1_n", m1_n, 1); chk("R9 mid-fetch addr", addr, 0);
    chk("R9 mid-fetch opcode", opcode, 0);
    #4 rst_n = 1'b1; prev_op = '0;
    repeat (2) @(posedge clk);
    #1 idle_chk(16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule